// File: doc/BRIEF.md
# Virtual-Neuron Multiply-Accumulate Element with Weight Checksum

This element computes a signed sum of products of 32-bit inputs and 32-bit stored weights for several virtual neurons that share one physical multiplier and accumulator. Each virtual neuron owns a private weight bank addressed by layer and input position. Weights are written through a load port while the element is idle. During that phase the shared adder also keeps a 64-bit running total of the sign-extended weights for every (virtual neuron, layer) pair.

A computation starts with a one-cycle start pulse that names the virtual neuron, the layer, the number of inputs and a threshold. Inputs then arrive over a valid/ready handshake, and input k is paired with weight slot k of that layer. Each weight that is fetched is multiplied with its input in a two-register multiplier and added to the accumulator. The same weight is also subtracted from a copy of the stored total. When the pipeline drains, a one-cycle done pulse presents two values together: the accumulated sum minus the threshold, and an error flag. The flag is set when the residual of the total is not zero, which indicates that the weight bank no longer matches what was loaded.

All arithmetic wraps modulo 2^64. For this reason the zero test on the residual is exact, whatever the weight values are.

Top module: `vneuron_mac`

## Requirements
- R1: While reset is held and on the first cycle after release, `busy`, `done`, `x_ready`, `result` and `chk_err` are all zero.
- R2: When idle, a load cycle with `ld_vn` below the virtual-neuron count writes `ld_weight` to slot `ld_idx` of layer `ld_layer` in that neuron's bank. The same cycle adds the sign-extended weight to that pair's 64-bit checksum. A load is ignored while busy, when `ld_vn` is out of range, or in the cycle a start is accepted.
- R3: A start pulse is accepted only when all of these hold: the element is idle, `go_vn` is in range, and `go_len` lies in 1..MAX_IN. An accepted start raises `busy` on the next cycle. Any other start pulse is ignored and leaves `busy` low.
- R4: `x_ready` is high only while busy and while fewer than `go_len` inputs have been accepted. The k-th accepted input (counting from 0) is paired with weight slot k.
- R5: `result` equals the sum of (signed input × signed weight) over the accepted inputs, minus `go_thresh`, modulo 2^64.
- R6: `done` is a single-cycle pulse. It rises on the ninth rising edge after the edge that accepts the last input, which gives a ten-register path. `busy` falls on that same edge.
- R7: `chk_err` is 0 when the computation reads every weight loaded for that (neuron, layer) exactly once since reset.
- R8: `chk_err` is 1 when the checksum residual is not zero. This happens, for example, when a slot was written twice, or when `go_len` is shorter than the number of weights that were loaded.
- R9: `result` and `chk_err` change only on the edge that raises `done`, and they hold their values until the next `done`.
- R10: Loads and computations for one (neuron, layer) pair leave the weights and the checksum of every other pair unchanged.
- R11: Gaps in `x_valid` change neither `result` nor the `done` latency, which is measured from the last accepted input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Weight load strobe |
| ld_vn | input | VN_W | Virtual neuron being loaded |
| ld_layer | input | LY_W | Layer being loaded |
| ld_idx | input | IX_W | Input position being loaded |
| ld_weight | input | DATA_W | Signed weight value |
| go | input | 1 | Start pulse |
| go_vn | input | VN_W | Virtual neuron to compute |
| go_layer | input | LY_W | Layer to compute |
| go_len | input | LEN_W | Number of inputs, 1..MAX_IN |
| go_thresh | input | 2*DATA_W | Threshold subtracted from the sum |
| x_valid | input | 1 | Input word valid |
| x_ready | output | 1 | Element accepts an input word |
| x_data | input | DATA_W | Signed input word |
| busy | output | 1 | A computation is in flight |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2*DATA_W | Sum of products minus threshold |
| chk_err | output | 1 | Nonzero checksum residual |

## Verification
The assertions assume two things about the stimulus. First, a start pulse or a load pulse lasts exactly one cycle. Second, `x_valid` is only meaningful while `x_ready` is high. The counter-based properties also assume that every computation is preceded by an accepted start. The bench drives all strobes for one cycle at the falling edge and raises `x_valid` only after an accepted start. It keeps each slot written once, except in the single test that deliberately rewrites a slot to corrupt the checksum.

// File: rtl/vneuron_pkg.sv
package vneuron_pkg;

   // Run state of the element
   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_RUN  = 1'b1
   } phase_e;

   // Control tag travelling beside the datapath
   typedef struct packed {
      logic vld;
      logic last;
   } tag_t;

endpackage

// File: rtl/vneuron_wbank.sv
module vneuron_wbank #(
   parameter int DW = 32,
   parameter int AW = 9
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/vneuron_mul.sv
module vneuron_mul #(
   parameter int DW    = 32,
   parameter bit SPLIT = 1'b1
) (
   input  logic            clk,
   input  logic [DW-1:0]   a,
   input  logic [DW-1:0]   b,
   output logic [2*DW-1:0] p
);
   localparam int PW = 2 * DW;
   localparam int H  = DW / 2;

   logic [PW-1:0] ae;
   assign ae = {{DW{a[DW-1]}}, a};

   if (SPLIT) begin : g_split
      // Stage A: two half-width partial products; stage B: recombine
      logic [PW-1:0] blo, bhi, plo_q, phi_q;
      assign blo = {{(PW-H){1'b0}}, b[H-1:0]};
      assign bhi = {{(PW-DW+H){b[DW-1]}}, b[DW-1:H]};
      always_ff @(posedge clk) begin
         plo_q <= ae * blo;
         phi_q <= ae * bhi;
         p     <= plo_q + (phi_q << H);
      end
   end else begin : g_flat
      logic [PW-1:0] be, pf_q;
      assign be = {{DW{b[DW-1]}}, b};
      always_ff @(posedge clk) begin
         pf_q <= ae * be;
         p    <= pf_q;
      end
   end
endmodule

// File: rtl/vneuron_ckstore.sv
module vneuron_ckstore #(
   parameter int ENTRIES = 24,
   parameter int AW      = 5,
   parameter int W       = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] tbl [ENTRIES];

   assign rdata = tbl[raddr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
      end else if (we) begin
         tbl[waddr] <= wdata;
      end
   end
endmodule

// File: rtl/vneuron_mac.sv
module vneuron_mac
   import vneuron_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int NUM_VN     = 3,
   parameter int NUM_LAYERS = 8,
   parameter int MAX_IN     = 64,
   parameter int PIPE_DEPTH = 10,
   parameter bit MUL_SPLIT  = 1'b1,
   localparam int ACC_W = 2 * DATA_W,
   localparam int VN_W  = $clog2(NUM_VN),
   localparam int LY_W  = $clog2(NUM_LAYERS),
   localparam int IX_W  = $clog2(MAX_IN),
   localparam int LEN_W = $clog2(MAX_IN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [VN_W-1:0]   ld_vn,
   input  logic [LY_W-1:0]   ld_layer,
   input  logic [IX_W-1:0]   ld_idx,
   input  logic [DATA_W-1:0] ld_weight,
   input  logic              go,
   input  logic [VN_W-1:0]   go_vn,
   input  logic [LY_W-1:0]   go_layer,
   input  logic [LEN_W-1:0]  go_len,
   input  logic [ACC_W-1:0]  go_thresh,
   input  logic              x_valid,
   output logic              x_ready,
   input  logic [DATA_W-1:0] x_data,
   output logic              busy,
   output logic              done,
   output logic [ACC_W-1:0]  result,
   output logic              chk_err
);
   localparam int BANK_AW = LY_W + IX_W;
   localparam int CK_AW   = VN_W + LY_W;
   localparam int CK_N    = NUM_VN << LY_W;
   localparam int DLY_N   = PIPE_DEPTH - 6;

   // Elaboration-time parameter checks
   if (NUM_VN < 2) begin : g_bad_vn
      $error("NUM_VN must be at least 2");
   end
   if ((NUM_LAYERS < 2) || ((1 << LY_W) != NUM_LAYERS)) begin : g_bad_ly
      $error("NUM_LAYERS must be a power of two >= 2");
   end
   if ((MAX_IN < 4) || ((1 << IX_W) != MAX_IN)) begin : g_bad_in
      $error("MAX_IN must be a power of two >= 4");
   end
   if (PIPE_DEPTH < 6) begin : g_bad_pd
      $error("PIPE_DEPTH must be at least 6");
   end
   if ((DATA_W < 4) || (DATA_W % 2 != 0)) begin : g_bad_dw
      $error("DATA_W must be even and >= 4");
   end

   function automatic logic [ACC_W-1:0] sx(input logic [DATA_W-1:0] v);
      return {{(ACC_W-DATA_W){v[DATA_W-1]}}, v};
   endfunction

   // ---------------- control ----------------
   phase_e            ph;
   logic [VN_W-1:0]   vn_q;
   logic [LY_W-1:0]   ly_q;
   logic [LEN_W-1:0]  len_q, issued;
   logic [ACC_W-1:0]  thr_q;
   logic              go_ok, ld_ok, take_x;

   assign busy    = (ph == PH_RUN);
   assign go_ok   = go && !busy && (int'(go_vn) < NUM_VN) &&
                    (go_len != '0) && (int'(go_len) <= MAX_IN);
   assign ld_ok   = ld_en && !busy && !go_ok && (int'(ld_vn) < NUM_VN);
   assign x_ready = busy && (issued < len_q);
   assign take_x  = x_valid && x_ready;

   // ---------------- weight banks ----------------
   logic [DATA_W-1:0]  bank_q [NUM_VN];
   logic [BANK_AW-1:0] rd_addr, wr_addr;
   assign rd_addr = {ly_q, issued[IX_W-1:0]};
   assign wr_addr = {ld_layer, ld_idx};

   for (genvar v = 0; v < NUM_VN; v++) begin : g_bank
      vneuron_wbank #(.DW(DATA_W), .AW(BANK_AW)) u_bank (
         .clk   (clk),
         .we    (ld_ok && (ld_vn == VN_W'(v))),
         .waddr (wr_addr),
         .wdata (ld_weight),
         .re    (take_x && (vn_q == VN_W'(v))),
         .raddr (rd_addr),
         .rdata (bank_q[v])
      );
   end

   // ---------------- datapath stages ----------------
   tag_t              t1, t2, t3;
   logic              l4;
   logic [DATA_W-1:0] x1, w1, w2, w3;
   logic [ACC_W-1:0]  p3, acc_q, resid_q;

   assign w1 = bank_q[vn_q];

   vneuron_mul #(.DW(DATA_W), .SPLIT(MUL_SPLIT)) u_mul (
      .clk (clk),
      .a   (x1),
      .b   (w1),
      .p   (p3)
   );

   // Shared adder: weight checksum while idle, accumulation while running
   logic [ACC_W-1:0] ck_rd, add_a, add_b, add_y;
   logic [CK_AW-1:0] ck_raddr;

   assign ck_raddr = go_ok ? {go_vn, go_layer} : {ld_vn, ld_layer};
   assign add_a    = busy ? acc_q : ck_rd;
   assign add_b    = busy ? p3 : sx(ld_weight);
   assign add_y    = add_a + add_b;

   vneuron_ckstore #(.ENTRIES(CK_N), .AW(CK_AW), .W(ACC_W)) u_ck (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ld_ok),
      .waddr ({ld_vn, ld_layer}),
      .wdata (add_y),
      .raddr (ck_raddr),
      .rdata (ck_rd)
   );

   always_ff @(posedge clk) begin
      if (take_x) x1 <= x_data;
      w2 <= w1;
      w3 <= w2;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph      <= PH_IDLE;
         vn_q    <= '0;
         ly_q    <= '0;
         len_q   <= '0;
         thr_q   <= '0;
         issued  <= '0;
         t1      <= '0;
         t2      <= '0;
         t3      <= '0;
         l4      <= 1'b0;
         acc_q   <= '0;
         resid_q <= '0;
      end else begin
         t1 <= '{vld: take_x, last: (issued == len_q - 1'b1)};
         t2 <= t1;
         t3 <= t2;
         l4 <= t3.vld && t3.last;
         if (go_ok) begin
            ph      <= PH_RUN;
            vn_q    <= go_vn;
            ly_q    <= go_layer;
            len_q   <= go_len;
            thr_q   <= go_thresh;
            issued  <= '0;
            acc_q   <= '0;
            resid_q <= ck_rd;
         end else begin
            if (take_x) issued <= issued + 1'b1;
            if (t3.vld) begin
               acc_q   <= add_y;
               resid_q <= resid_q - sx(w3);
            end
            if (dv[DLY_N]) ph <= PH_IDLE;
         end
      end
   end

   // ---------------- result alignment ----------------
   logic             dv   [DLY_N+1];
   logic [ACC_W-1:0] dres [DLY_N+1];
   logic             derr [DLY_N+1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i <= DLY_N; i++) begin
            dv[i]   <= 1'b0;
            dres[i] <= '0;
            derr[i] <= 1'b0;
         end
         done    <= 1'b0;
         result  <= '0;
         chk_err <= 1'b0;
      end else begin
         dv[0]   <= l4;
         dres[0] <= acc_q - thr_q;
         derr[0] <= |resid_q;
         for (int i = 1; i <= DLY_N; i++) begin
            dv[i]   <= dv[i-1];
            dres[i] <= dres[i-1];
            derr[i] <= derr[i-1];
         end
         done <= dv[DLY_N];
         if (dv[DLY_N]) begin
            result  <= dres[DLY_N];
            chk_err <= derr[DLY_N];
         end
      end
   end
endmodule

// File: rtl/vneuron_mac_chk.sv
module vneuron_mac_chk #(
   parameter int DATA_W = 32,
   parameter int NUM_VN = 3,
   parameter int MAX_IN = 64,
   parameter int VN_W   = 2,
   parameter int LEN_W  = 7
) (
   input logic                clk,
   input logic                rst_n,
   input logic                go,
   input logic [VN_W-1:0]     go_vn,
   input logic [LEN_W-1:0]    go_len,
   input logic                x_valid,
   input logic                x_ready,
   input logic                busy,
   input logic                done,
   input logic [2*DATA_W-1:0] result,
   input logic                chk_err
);
   logic             start_ok;
   logic [LEN_W-1:0] seen, want;

   assign start_ok = go && !busy && (int'(go_vn) < NUM_VN) &&
                     (go_len != '0) && (int'(go_len) <= MAX_IN);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen <= '0;
         want <= '0;
      end else if (start_ok) begin
         seen <= '0;
         want <= go_len;
      end else if (x_valid && x_ready) begin
         seen <= seen + 1'b1;
      end
   end

   assert_idle_not_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
      x_ready |-> busy);

   assert_accept_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (x_valid && x_ready) |-> (seen < want));

   assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start_ok |=> busy);

   assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_done_all_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (seen == want));

   assert_outputs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(result) && $stable(chk_err)));
endmodule

bind vneuron_mac vneuron_mac_chk #(
   .DATA_W (DATA_W),
   .NUM_VN (NUM_VN),
   .MAX_IN (MAX_IN),
   .VN_W   (VN_W),
   .LEN_W  (LEN_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .go      (go),
   .go_vn   (go_vn),
   .go_len  (go_len),
   .x_valid (x_valid),
   .x_ready (x_ready),
   .busy    (busy),
   .done    (done),
   .result  (result),
   .chk_err (chk_err)
);

// File: tb/vneuron_mac_tb.sv
module vneuron_mac_tb;
   localparam int NV = 3, NL = 8, MI = 64, PD = 10;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        ld_en = 0, go = 0, x_valid = 0;
   logic [1:0]  ld_vn = 0, go_vn = 0;
   logic [2:0]  ld_layer = 0, go_layer = 0;
   logic [5:0]  ld_idx = 0;
   logic [31:0] ld_weight = 0, x_data = 0;
   logic [6:0]  go_len = 0;
   logic [63:0] go_thresh = 0;
   logic        x_ready, busy, done, chk_err;
   logic [63:0] result;

   vneuron_mac u_dut (
      .clk(clk), .rst_n(rst_n),
      .ld_en(ld_en), .ld_vn(ld_vn), .ld_layer(ld_layer), .ld_idx(ld_idx), .ld_weight(ld_weight),
      .go(go), .go_vn(go_vn), .go_layer(go_layer), .go_len(go_len), .go_thresh(go_thresh),
      .x_valid(x_valid), .x_ready(x_ready), .x_data(x_data),
      .busy(busy), .done(done), .result(result), .chk_err(chk_err)
   );

   always #5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_run = 0, n_fail = 0;

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Bench-side record of what was loaded
   logic [31:0] sh_w  [NV][NL][MI];
   logic [63:0] sh_ck [NV][NL];

   function automatic logic [31:0] wgen(int pat, int vn, int ly, int k);
      case (pat)
         0:       return 32'(k + 1 + vn * 3);
         1:       return (32'(k) * 32'h9E37_79B1) ^ (32'(ly) * 32'h0100_0193) ^ 32'(vn);
         default: return (k % 2 == 1) ? -32'(k * 7 + 3) : 32'(k * 11 + 2);
      endcase
   endfunction

   function automatic logic [31:0] xgen(int pat, int k);
      case (pat)
         0:       return 32'(k + 2);
         1:       return 32'h7FFF_FFFF - 32'(k) * 32'h0101_0101;
         default: return -32'((k + 1) * 1000);
      endcase
   endfunction

   function automatic logic [63:0] sx(logic [31:0] v);
      return {{32{v[31]}}, v};
   endfunction

   typedef struct packed {
      logic [1:0]  vn;
      logic [2:0]  ly;
      logic [6:0]  len;
      logic [63:0] thr;
      logic [1:0]  pat;
      logic [1:0]  gap;
   } vec_t;

   localparam int NVEC = 6;
   localparam vec_t VEC [NVEC] = '{
      '{2'd0, 3'd0, 7'd4,  64'd10,                 2'd0, 2'd0},
      '{2'd1, 3'd3, 7'd8,  64'hFFFF_FFFF_FFFF_FFFB, 2'd2, 2'd1},
      '{2'd2, 3'd7, 7'd64, 64'd0,                  2'd1, 2'd0},
      '{2'd0, 3'd5, 7'd1,  64'h123,                2'd1, 2'd0},
      '{2'd1, 3'd1, 7'd16, 64'd7,                  2'd1, 2'd3},
      '{2'd2, 3'd2, 7'd5,  64'd0,                  2'd2, 2'd0}
   };

   task automatic load(input int vn, input int ly, input int idx, input logic [31:0] w, input bit apply);
      @(negedge clk);
      ld_en = 1; ld_vn = 2'(vn); ld_layer = 3'(ly); ld_idx = 6'(idx); ld_weight = w;
      @(negedge clk);
      ld_en = 0;
      if (apply) begin
         sh_w[vn][ly][idx] = w;
         sh_ck[vn][ly] = sh_ck[vn][ly] + sx(w);
      end
   endtask

   task automatic run_vec(input int vn, input int ly, input int len, input logic [63:0] thr,
                          input int pat, input int gap, input bit poke, input string tag);
      logic [63:0] exp_res, resid;
      logic        exp_err;
      int          last, wd;
      exp_res = 0;
      resid   = sh_ck[vn][ly];
      for (int k = 0; k < len; k++) begin
         exp_res = exp_res + sx(xgen(pat, k)) * sx(sh_w[vn][ly][k]);
         resid   = resid - sx(sh_w[vn][ly][k]);
      end
      exp_res = exp_res - thr;
      exp_err = (resid != 0);

      @(negedge clk);
      go = 1; go_vn = 2'(vn); go_layer = 3'(ly); go_len = 7'(len); go_thresh = thr;
      @(negedge clk);
      go = 0;
      if (poke) begin
         // load and second start while busy: both must be ignored (R2, R3)
         ld_en = 1; ld_vn = 2'(vn); ld_layer = 3'(ly); ld_idx = 0; ld_weight = 32'hDEAD_BEEF;
         go = 1; go_vn = 0; go_layer = 0; go_len = 1; go_thresh = 64'h55;
         @(negedge clk);
         ld_en = 0; go = 0;
      end
      last = cyc;
      for (int k = 0; k < len; k++) begin
         if (k > 0) repeat (gap) begin x_valid = 0; @(negedge clk); end
         x_valid = 1; x_data = xgen(pat, k);
         while (!x_ready) @(negedge clk);
         @(negedge clk);
         last = cyc;
      end
      x_valid = 0;
      check({tag, " R4 ready low after last input"}, 64'(x_ready), 64'd0);
      check({tag, " R3 busy during run"}, 64'(busy), 64'd1);
      wd = 0;
      while (!done && wd < 100) begin @(negedge clk); wd++; end
      check({tag, " R6 done latency"}, 64'(cyc - last), 64'(PD - 1));
      check({tag, " R6 busy falls with done"}, 64'(busy), 64'd0);
      check({tag, " R5 R11 R10 result"}, result, exp_res);
      check({tag, " R7 R8 checksum flag"}, 64'(chk_err), 64'(exp_err));
      @(negedge clk);
      check({tag, " R6 done one cycle"}, 64'(done), 64'd0);
   endtask

   // Watchdog: an expired run counts as a failure and still reports
   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [63:0] held;
      for (int v = 0; v < NV; v++)
         for (int l = 0; l < NL; l++) sh_ck[v][l] = '0;

      repeat (3) @(negedge clk);
      check("R1 busy in reset", 64'(busy), 64'd0);
      rst_n = 1;
      @(negedge clk);
      check("R1 busy", 64'(busy), 64'd0);
      check("R1 done", 64'(done), 64'd0);
      check("R1 x_ready", 64'(x_ready), 64'd0);
      check("R1 result", result, 64'd0);
      check("R1 chk_err", 64'(chk_err), 64'd0);

      // Load every vector's weights (R2)
      for (int e = 0; e < NVEC; e++)
         for (int k = 0; k < int'(VEC[e].len); k++)
            load(VEC[e].vn, VEC[e].ly, k, wgen(VEC[e].pat, VEC[e].vn, VEC[e].ly, k), 1'b1);

      // Vector walk: R5, R6, R7, R10, R11 (vector 1 and 4 use gaps)
      for (int e = 0; e < NVEC; e++)
         run_vec(VEC[e].vn, VEC[e].ly, VEC[e].len, VEC[e].thr, VEC[e].pat, VEC[e].gap,
                 1'b0, $sformatf("vec%0d", e));

      // R9: outputs hold after done
      held = result;
      repeat (6) @(negedge clk);
      check("R9 result held", result, held);
      check("R9 flag held", 64'(chk_err), 64'd0);

      // R3: invalid starts ignored
      @(negedge clk); go = 1; go_vn = 0; go_layer = 0; go_len = 0;
      @(negedge clk); go = 0;
      check("R3 zero length ignored", 64'(busy), 64'd0);
      go = 1; go_vn = 3; go_len = 4;
      @(negedge clk); go = 0;
      check("R3 neuron index out of range ignored", 64'(busy), 64'd0);
      go = 1; go_vn = 1; go_len = 7'd65;
      @(negedge clk); go = 0;
      check("R3 length above maximum ignored", 64'(busy), 64'd0);

      // R2/R3: load and start during a run are ignored; rerun shows no change
      run_vec(VEC[5].vn, VEC[5].ly, VEC[5].len, VEC[5].thr, VEC[5].pat, 0, 1'b1, "busy-poke R2 R3");
      run_vec(VEC[5].vn, VEC[5].ly, VEC[5].len, VEC[5].thr, VEC[5].pat, 0, 1'b0, "after-poke R2");

      // R2: load to an out-of-range neuron index is ignored
      load(3, 5, 0, 32'h1357_9BDF, 1'b0);
      run_vec(VEC[3].vn, VEC[3].ly, VEC[3].len, VEC[3].thr, VEC[3].pat, 0, 1'b0, "bad-vn-load R2");

      // R8: rewriting one slot corrupts the checksum
      load(0, 0, 2, wgen(0, 0, 0, 2), 1'b1);
      run_vec(0, 0, 4, 64'd10, 0, 0, 1'b0, "rewrite R8");

      // R8: reading fewer weights than loaded leaves a residual
      run_vec(VEC[1].vn, VEC[1].ly, 7, VEC[1].thr, VEC[1].pat, 0, 1'b0, "short R8");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule